// File: doc/BRIEF.md
# Front-Side Bus Address Parity Unit

This block protects the two-subphase request phase of a shared processor bus with a pair of parity lines. It has two independent halves that share one clock. The requester half watches its own address strobe together with a 37-line address/type field and a 5-line transaction-kind field. It drives the matching parity pair one clock after each subphase. The receiver half captures the same fields when it sees a strobe and rebuilds the expected pair. It compares that pair with the parity received one clock later and reports any mismatch per parity line and per subphase.

All field lines are carried at their electrical levels, so their asserted state is low. In the first subphase the fields carry the address. In the second subphase, which always follows on the next clock, the same lines carry transaction-type information. The two parity lines protect different line groups, and the groups trade places between the subphases. The receiver keeps sticky copies of its error pulses until software-independent logic pulses a clear input. It also flags a strobe that arrives before the previous transaction's checks are finished.

Top module: `fsb_addr_parity`

## Requirements
- R1: A parity line is high when an even number of the lines it covers are low, and low when that number is odd; with every covered line high it is high.
- R2: In subphase 1 (the strobe cycle), parity bit 0 covers address lines `addr[36:21]` and parity bit 1 covers `addr[20:0]` together with all five kind lines.
- R3: In subphase 2 (the cycle after the strobe), the groups swap: bit 1 covers `addr[36:21]` and bit 0 covers `addr[20:0]` plus the kind lines.
- R4: `tx_par_o` shows the subphase-1 pair in the cycle after `tx_strobe_i` and the subphase-2 pair in the cycle after that; in every other cycle it is `2'b11`.
- R5: The receiver compares `rx_par_i` in the cycle after `rx_strobe_i` with the subphase-1 pair. Each mismatching bit is set in `err_sp1_o` for exactly one cycle, two cycles after the strobe.
- R6: The receiver compares `rx_par_i` two cycles after the strobe with the subphase-2 pair. Each mismatching bit is set in `err_sp2_o` for exactly one cycle, three cycles after the strobe.
- R7: `err_sticky_o` is `{err_sp2_o[1], err_sp2_o[0], err_sp1_o[1], err_sp1_o[0]}` accumulated. A bit sets in the same cycle as its pulse and holds until `clr_i` is sampled high, which clears it from the next cycle; an error arriving with the clear still sets its bit.
- R8: An `rx_strobe_i` in either of the two cycles after an undiscarded strobe raises `proto_err_o` for one cycle on the next cycle. The remaining checks of the older transaction are dropped, with no error pulse, and the new strobe starts a fresh transaction.
- R9: Synchronous reset clears the parity output to `2'b11` and clears all error pulses, sticky bits and pending checks. A transaction in flight when reset is applied raises no error afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_strobe_i | input | 1 | Requester address strobe, one-cycle pulse, active high |
| tx_addr_i | input | 37 | Requester address/type lines, electrical level |
| tx_kind_i | input | 5 | Requester transaction-kind lines, electrical level |
| tx_par_o | output | 2 | Generated parity pair |
| rx_strobe_i | input | 1 | Observed address strobe, active high |
| rx_addr_i | input | 37 | Observed address/type lines |
| rx_kind_i | input | 5 | Observed transaction-kind lines |
| rx_par_i | input | 2 | Observed parity pair |
| clr_i | input | 1 | Clears the sticky error register |
| err_sp1_o | output | 2 | Subphase-1 mismatch pulse, one bit per parity line |
| err_sp2_o | output | 2 | Subphase-2 mismatch pulse, one bit per parity line |
| err_sticky_o | output | 4 | Accumulated mismatches |
| proto_err_o | output | 1 | Strobe arrived while a check was pending |

## Verification
The bench aims at the group boundary: it drives single low lines at the top address line and on the kind field. A design that swapped the groups, or failed to swap them in subphase 2, would then flag the wrong bit. All-low fields separate true parity from an odd/even inversion, since both groups have even width. Strobes one and two cycles apart must produce a protocol pulse and no parity error; a design that kept the stale check would report a false mismatch. Reset in mid-transaction and a clear arriving together with an error catch designs that leak old checks or let the clear win.

// File: rtl/fsb_par_pkg.sv
package fsb_par_pkg;

   // Which coverage map a parity pair is built with
   typedef enum logic {
      SP_ADDR = 1'b0,   // first subphase: bit0 = upper group
      SP_TYPE = 1'b1    // second subphase: bit1 = upper group
   } subphase_e;

   localparam logic [1:0] PAR_IDLE = 2'b11;

endpackage

// File: rtl/fsb_par_calc.sv
module fsb_par_calc
   import fsb_par_pkg::*;
#(
   parameter int ADDR_W = 37,
   parameter int KIND_W = 5,
   parameter int LO_W   = 21
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [KIND_W-1:0] kind_i,
   input  subphase_e         sel_i,
   output logic [1:0]        pair_o
);

   localparam int HI_W  = ADDR_W - LO_W;
   localparam int LOG_W = LO_W + KIND_W;

   if (LO_W < 1 || LO_W >= ADDR_W) begin : g_bad_split
      $error("fsb_par_calc: LO_W must lie between 1 and ADDR_W-1");
   end
   if (KIND_W < 1) begin : g_bad_kind
      $error("fsb_par_calc: KIND_W must be at least 1");
   end

   logic [HI_W-1:0]  hi_lines;
   logic [LOG_W-1:0] lo_lines;
   logic             hi_par;
   logic             lo_par;

   assign hi_lines = addr_i[ADDR_W-1:LO_W];
   assign lo_lines = {addr_i[LO_W-1:0], kind_i};

   // Odd count of low lines drives the line low
   assign hi_par = ~(^(~hi_lines));
   assign lo_par = ~(^(~lo_lines));

   always_comb begin
      if (sel_i == SP_ADDR) pair_o = {lo_par, hi_par};
      else                  pair_o = {hi_par, lo_par};
   end

endmodule

// File: rtl/fsb_par_gen.sv
module fsb_par_gen
   import fsb_par_pkg::*;
#(
   parameter int ADDR_W = 37,
   parameter int KIND_W = 5,
   parameter int LO_W   = 21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [KIND_W-1:0] kind_i,
   output logic [1:0]        par_o
);

   logic       sp2_due;
   logic [1:0] pair;
   subphase_e  sel;

   assign sel = strobe_i ? SP_ADDR : SP_TYPE;

   fsb_par_calc #(.ADDR_W(ADDR_W), .KIND_W(KIND_W), .LO_W(LO_W)) u_calc (
      .addr_i (addr_i),
      .kind_i (kind_i),
      .sel_i  (sel),
      .pair_o (pair)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sp2_due <= 1'b0;
         par_o   <= PAR_IDLE;
      end else begin
         sp2_due <= strobe_i;
         if (strobe_i || sp2_due) par_o <= pair;
         else                     par_o <= PAR_IDLE;
      end
   end

   // R4
   idle_par_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(strobe_i) && !$past(strobe_i, 2)) |-> (par_o == PAR_IDLE));

endmodule

// File: rtl/fsb_par_chk.sv
module fsb_par_chk
   import fsb_par_pkg::*;
#(
   parameter int ADDR_W = 37,
   parameter int KIND_W = 5,
   parameter int LO_W   = 21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [KIND_W-1:0] kind_i,
   input  logic [1:0]        par_i,
   output logic [1:0]        err_sp1_o,
   output logic [1:0]        err_sp2_o,
   output logic [3:0]        sticky_o,
   output logic              proto_o
);

   logic       wait1;      // subphase-1 parity due this cycle
   logic       wait2;      // subphase-2 parity due this cycle
   logic [1:0] exp1;
   logic [1:0] exp2;
   logic [1:0] pair;
   logic [1:0] new1;
   logic [1:0] new2;
   logic       clash;
   subphase_e  sel;

   assign sel   = (wait1 && !strobe_i) ? SP_TYPE : SP_ADDR;
   assign clash = strobe_i && (wait1 || wait2);
   assign new1  = (wait1 && !strobe_i) ? (par_i ^ exp1) : 2'b00;
   assign new2  = (wait2 && !strobe_i) ? (par_i ^ exp2) : 2'b00;

   fsb_par_calc #(.ADDR_W(ADDR_W), .KIND_W(KIND_W), .LO_W(LO_W)) u_calc (
      .addr_i (addr_i),
      .kind_i (kind_i),
      .sel_i  (sel),
      .pair_o (pair)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wait1     <= 1'b0;
         wait2     <= 1'b0;
         exp1      <= 2'b00;
         exp2      <= 2'b00;
         err_sp1_o <= 2'b00;
         err_sp2_o <= 2'b00;
         sticky_o  <= 4'b0000;
         proto_o   <= 1'b0;
      end else begin
         wait1 <= strobe_i;
         wait2 <= wait1 && !strobe_i;
         if (strobe_i)   exp1 <= pair;
         else if (wait1) exp2 <= pair;
         err_sp1_o <= new1;
         err_sp2_o <= new2;
         proto_o   <= clash;
         sticky_o  <= (clr_i ? 4'b0000 : sticky_o) | {new2, new1};
      end
   end

   // R5
   sp1_timing_chk: assert property (@(posedge clk) disable iff (rst)
      (|err_sp1_o) |-> ($past(strobe_i, 2) && !$past(strobe_i)));

   // R6
   sp2_timing_chk: assert property (@(posedge clk) disable iff (rst)
      (|err_sp2_o) |-> $past(strobe_i, 3));

   // R7
   sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
      ((sticky_o & {err_sp2_o, err_sp1_o}) == {err_sp2_o, err_sp1_o}));

   // R7
   sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(clr_i) && !(|{err_sp2_o, err_sp1_o})) |-> (sticky_o == 4'b0000));

   // R8
   proto_excl_chk: assert property (@(posedge clk) disable iff (rst)
      proto_o |-> ($past(strobe_i) && !(|{err_sp2_o, err_sp1_o})));

endmodule

// File: rtl/fsb_addr_parity.sv
module fsb_addr_parity #(
   parameter int ADDR_W = 37,
   parameter int KIND_W = 5,
   parameter int LO_W   = 21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tx_strobe_i,
   input  logic [ADDR_W-1:0] tx_addr_i,
   input  logic [KIND_W-1:0] tx_kind_i,
   output logic [1:0]        tx_par_o,
   input  logic              rx_strobe_i,
   input  logic [ADDR_W-1:0] rx_addr_i,
   input  logic [KIND_W-1:0] rx_kind_i,
   input  logic [1:0]        rx_par_i,
   input  logic              clr_i,
   output logic [1:0]        err_sp1_o,
   output logic [1:0]        err_sp2_o,
   output logic [3:0]        err_sticky_o,
   output logic              proto_err_o
);

   fsb_par_gen #(.ADDR_W(ADDR_W), .KIND_W(KIND_W), .LO_W(LO_W)) u_gen (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (tx_strobe_i),
      .addr_i   (tx_addr_i),
      .kind_i   (tx_kind_i),
      .par_o    (tx_par_o)
   );

   fsb_par_chk #(.ADDR_W(ADDR_W), .KIND_W(KIND_W), .LO_W(LO_W)) u_chk (
      .clk       (clk),
      .rst       (rst),
      .clr_i     (clr_i),
      .strobe_i  (rx_strobe_i),
      .addr_i    (rx_addr_i),
      .kind_i    (rx_kind_i),
      .par_i     (rx_par_i),
      .err_sp1_o (err_sp1_o),
      .err_sp2_o (err_sp2_o),
      .sticky_o  (err_sticky_o),
      .proto_o   (proto_err_o)
   );

   // R9
   rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!(|{err_sp1_o, err_sp2_o, err_sticky_o}) && !proto_err_o));

endmodule

// File: tb/fsb_addr_parity_tb.sv
module fsb_addr_parity_tb;

   localparam int AW = 37;
   localparam int KW = 5;
   localparam int LW = 21;

   logic          clk = 1'b0;
   logic          rst;
   logic          tx_strobe_i, rx_strobe_i, clr_i;
   logic [AW-1:0] tx_addr_i, rx_addr_i;
   logic [KW-1:0] tx_kind_i, rx_kind_i;
   logic [1:0]    rx_par_i, tx_par_o, err_sp1_o, err_sp2_o;
   logic [3:0]    err_sticky_o;
   logic          proto_err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [3:0] sticky_exp = 4'b0;

   always #5 clk = ~clk;

   fsb_addr_parity u_dut (
      .clk(clk), .rst(rst),
      .tx_strobe_i(tx_strobe_i), .tx_addr_i(tx_addr_i), .tx_kind_i(tx_kind_i),
      .tx_par_o(tx_par_o),
      .rx_strobe_i(rx_strobe_i), .rx_addr_i(rx_addr_i), .rx_kind_i(rx_kind_i),
      .rx_par_i(rx_par_i), .clr_i(clr_i),
      .err_sp1_o(err_sp1_o), .err_sp2_o(err_sp2_o),
      .err_sticky_o(err_sticky_o), .proto_err_o(proto_err_o)
   );

   // Expected pair from line-level counting of low lines
   function automatic logic [1:0] exp_pair(input logic [AW-1:0] a,
                                            input logic [KW-1:0] k,
                                            input bit second);
      int hi_low = 0;
      int lo_low = 0;
      logic ph, pl;
      for (int i = 0; i < AW; i++) begin
         if (a[i] == 1'b0) begin
            if (i >= LW) hi_low++;
            else         lo_low++;
         end
      end
      for (int i = 0; i < KW; i++) if (k[i] == 1'b0) lo_low++;
      ph = (hi_low % 2 == 0);
      pl = (lo_low % 2 == 0);
      return second ? {ph, pl} : {pl, ph};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic stb, input logic [AW-1:0] a,
                        input logic [KW-1:0] k, input logic [1:0] p);
      tx_strobe_i = stb; rx_strobe_i = stb;
      tx_addr_i = a; rx_addr_i = a;
      tx_kind_i = k; rx_kind_i = k;
      rx_par_i = p;
   endtask

   task automatic idle();
      drive(1'b0, '1, '1, 2'b11);
   endtask

   // One full transaction; f1/f2 flip received parity bits
   task automatic txn(input logic [AW-1:0] a1, input logic [KW-1:0] k1,
                      input logic [AW-1:0] a2, input logic [KW-1:0] k2,
                      input logic [1:0] f1, input logic [1:0] f2, input string tag);
      logic [1:0] e1, e2;
      e1 = exp_pair(a1, k1, 1'b0);
      e2 = exp_pair(a2, k2, 1'b1);
      @(negedge clk); drive(1'b1, a1, k1, 2'b11);
      @(negedge clk);
      check({tag, " R4 sp1 pair"}, tx_par_o, e1);
      drive(1'b0, a2, k2, e1 ^ f1);
      @(negedge clk);
      check({tag, " R4 sp2 pair"}, tx_par_o, e2);
      check({tag, " R5 sp1 error"}, err_sp1_o, f1);
      idle(); rx_par_i = e2 ^ f2;
      @(negedge clk);
      idle();
      sticky_exp = sticky_exp | {f2, f1};
      check({tag, " R6 sp2 error"}, err_sp2_o, f2);
      check({tag, " R5 pulse width"}, err_sp1_o, 2'b00);
      check({tag, " R4 idle pair"}, tx_par_o, 2'b11);
      check({tag, " R7 sticky"}, err_sticky_o, sticky_exp);
   endtask

   task automatic clear_sticky();
      @(negedge clk); clr_i = 1'b1;
      @(negedge clk); clr_i = 1'b0;
      sticky_exp = 4'b0;
      check("R7 cleared", err_sticky_o, 4'b0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a1, a2, b1, b2;
      logic [KW-1:0] k1, k2, m1, m2;
      logic [1:0]    e;
      void'($urandom(32'h5eed_0042));
      rst = 1'b1; clr_i = 1'b0; idle();
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 reset par", tx_par_o, 2'b11);
      check("R9 reset errors", {err_sp1_o, err_sp2_o, err_sticky_o, proto_err_o}, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1: all high and all low both give 2'b11 (even groups)
      txn('1, '1, '1, '1, 2'b00, 2'b00, "R1 all-high");
      check("R1 all-high pair", exp_pair('1, '1, 1'b0), 2'b11);
      txn('0, '0, '0, '0, 2'b00, 2'b00, "R1 all-low");
      // R2/R3: single low line on the top address line and on kind bit 0
      a1 = '1; a1[AW-1] = 1'b0;
      check("R2 top line sp1", exp_pair(a1, '1, 1'b0), 2'b10);
      check("R3 top line sp2", exp_pair(a1, '1, 1'b1), 2'b01);
      txn(a1, '1, a1, '1, 2'b00, 2'b00, "R2 R3 top line");
      k1 = 5'b11110;
      txn('1, k1, '1, k1, 2'b00, 2'b00, "R2 R3 kind line");
      a1 = '1; a1[LW] = 1'b0; a2 = '1; a2[LW-1] = 1'b0;
      txn(a1, '1, a2, '1, 2'b00, 2'b00, "R2 R3 boundary");

      // R5/R6/R7: injected mismatches, then clear
      txn(a1, '1, a2, '1, 2'b01, 2'b10, "R5 R6 flip");
      clear_sticky();

      // R7: clear in the same cycle as an error still sets it
      a1 = {$urandom, $urandom}; k1 = $urandom;
      e = exp_pair(a1, k1, 1'b0);
      @(negedge clk); drive(1'b1, a1, k1, 2'b11);
      @(negedge clk); drive(1'b0, a1, k1, e ^ 2'b10); clr_i = 1'b1;
      @(negedge clk); clr_i = 1'b0;
      check("R7 error beats clear", err_sticky_o, 4'b0010);
      idle();
      repeat (2) @(negedge clk);
      clear_sticky();

      // Constrained random transactions
      for (int n = 0; n < 300; n++) begin
         logic [1:0] f1, f2;
         a1 = {$urandom, $urandom}; a2 = {$urandom, $urandom};
         k1 = $urandom; k2 = $urandom;
         f1 = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
         f2 = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
         txn(a1, k1, a2, k2, f1, f2, "rand");
         if (n % 25 == 24) clear_sticky();
      end
      clear_sticky();

      // R8: second strobe one cycle later
      a1 = {$urandom, $urandom}; k1 = $urandom;
      b1 = {$urandom, $urandom}; m1 = $urandom;
      b2 = {$urandom, $urandom}; m2 = $urandom;
      @(negedge clk); drive(1'b1, a1, k1, 2'b11);
      @(negedge clk); drive(1'b1, b1, m1, ~exp_pair(a1, k1, 1'b0));
      @(negedge clk);
      check("R8 proto one apart", proto_err_o, 1'b1);
      check("R8 dropped sp1", err_sp1_o, 2'b00);
      drive(1'b0, b2, m2, exp_pair(b1, m1, 1'b0));
      @(negedge clk);
      check("R8 new sp1 ok", err_sp1_o, 2'b00);
      check("R8 proto width", proto_err_o, 1'b0);
      idle(); rx_par_i = exp_pair(b2, m2, 1'b1) ^ 2'b01;
      @(negedge clk); idle();
      check("R8 new sp2 checked", err_sp2_o, 2'b01);
      check("R8 sticky", err_sticky_o, 4'b0100);
      clear_sticky();

      // R8: second strobe two cycles later
      a1 = {$urandom, $urandom}; k1 = $urandom;
      a2 = {$urandom, $urandom}; k2 = $urandom;
      b1 = {$urandom, $urandom}; m1 = $urandom;
      b2 = {$urandom, $urandom}; m2 = $urandom;
      @(negedge clk); drive(1'b1, a1, k1, 2'b11);
      @(negedge clk); drive(1'b0, a2, k2, exp_pair(a1, k1, 1'b0));
      @(negedge clk);
      check("R8 sp1 before clash", err_sp1_o, 2'b00);
      drive(1'b1, b1, m1, ~exp_pair(a2, k2, 1'b1));
      @(negedge clk);
      check("R8 proto two apart", proto_err_o, 1'b1);
      check("R8 dropped sp2", err_sp2_o, 2'b00);
      drive(1'b0, b2, m2, exp_pair(b1, m1, 1'b0));
      @(negedge clk);
      idle(); rx_par_i = exp_pair(b2, m2, 1'b1);
      @(negedge clk); idle();
      check("R8 clean after clash", {err_sp1_o, err_sp2_o, err_sticky_o}, 0);

      // R9: reset with a transaction in flight
      a1 = {$urandom, $urandom}; k1 = $urandom;
      @(negedge clk); drive(1'b1, a1, k1, 2'b11);
      @(negedge clk); drive(1'b0, a1, k1, ~exp_pair(a1, k1, 1'b0)); rst = 1'b1;
      @(negedge clk); rx_par_i = ~exp_pair(a1, k1, 1'b1);
      @(negedge clk); rst = 1'b0; idle();
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R9 no error after reset",
               {err_sp1_o, err_sp2_o, err_sticky_o, proto_err_o}, 0);
         check("R9 idle par", tx_par_o, 2'b11);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule